// File: doc/BRIEF.md
# Three-Channel Bus Timer

This peripheral holds three independent 32-bit counters behind a small word-addressed register bus. Each channel has a live count, a reload value and two compare values. A shared control word turns each channel on or off, picks its count source and gates its wrap event into the interrupt status. One global bit sets the count direction for all channels. The count source is either every bus clock or the rising edges of that channel's external pulse input. The external pulses are synchronised into the bus clock domain and are never used as a clock.

In a typical setup, software leaves one channel running downward as a timestamp source. It uses a second channel as an event timer: it reads the live count, subtracts a delay and writes the result to a compare register. When the count reaches that value, a status bit is set. Status bits are sticky and are cleared by writing 1 to them. A mask register chooses which status bits reach the single interrupt line.

Top module: `tri_timer`

## Requirements
- R1: After reset, every reload register reads 0xFFFFFFFF. Every other register reads 0, all channels are stopped and `irq_o` is low.
- R2: A channel whose enable bit (control bit 3k for channel k=0..2) is set, with source bit 3k+1 clear and direction bit 9 clear, decrements its count by one on every bus clock after the cycle in which the enable is written.
- R3: With control bit 9 set, enabled channels increment by one per tick.
- R4: A down-counting channel that ticks at count 0 loads its reload value. If its wrap-interrupt bit (control bit 3k+2) is set, status bit 3k+2 is set in the same cycle. If that bit is clear, the status bit stays unchanged.
- R5: An up-counting channel that ticks at count 0xFFFFFFFF loads its reload value and raises status bit 3k+2 when its wrap-interrupt bit is set.
- R6: When a tick brings channel k's count to its compare-A value (bank offset +0x8), status bit 3k is set. When a tick brings it to its compare-B value (+0xC), status bit 3k+1 is set.
- R7: Clearing one channel's enable bit freezes that channel's count while the other enabled channels keep counting.
- R8: With source bit 3k+1 set, channel k counts once for each rising edge of `ext_clk_i[k]`, three bus clocks after that edge. A steady level never counts, and edges are ignored while the channel is disabled.
- R9: Writing the status register (0x34) clears each bit written as 1 and leaves bits written as 0 unchanged. No status bit clears in any other way.
- R10: `irq_o` is high exactly when a status bit is set whose mask bit (register 0x38) is 0.
- R11: If a status bit's event occurs in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R12: A software write to a count register (bank offset +0x0) takes effect even when the channel ticks in the same cycle. A read returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address of the register; bits 1:0 are ignored |
| we_i | input | 1 | Write strobe, one word per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| ext_clk_i | input | 3 | External pulse input, one per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land on the same status bit in one bus cycle: a hardware event that sets it and a software write that clears it. To force this, the bench starts a channel counting down toward a compare value and times the write-one-to-clear so that it commits on the exact clock edge where the count reaches that value. It then reads the status back and expects the bit to be set. A second clear one cycle later must return the status to zero. Software count writes that collide with a tick are tested the same way, by writing a running channel's count and reading back the exact written value.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  // field order inside a channel's 3-bit group (control and status)
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_SRC  = 1;
  localparam int unsigned CTL_WIE  = 2;
  localparam int unsigned ST_CMPA  = 0;
  localparam int unsigned ST_CMPB  = 1;
  localparam int unsigned ST_WRAP  = 2;
  localparam int unsigned GRP_BITS = 3;

  typedef enum logic [1:0] {
    BK_COUNT  = 2'd0,
    BK_RELOAD = 2'd1,
    BK_CMPA   = 2'd2,
    BK_CMPB   = 2'd3
  } bank_reg_e;
endpackage

// File: rtl/ext_tick_sync.sv
module ext_tick_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ext_i,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q & ~s3_q;

  // R8
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o != '0) |=> ((edge_o & $past(edge_o)) == '0));
endmodule

// File: rtl/timer_chan.sv
module timer_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         up_i,
  input  logic         wie_i,
  input  logic         cnt_we_i,
  input  logic         rld_we_i,
  input  logic         cmpa_we_i,
  input  logic         cmpb_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic [W-1:0] cmpa_o,
  output logic [W-1:0] cmpb_o,
  output logic         cmpa_hit_o,
  output logic         cmpb_hit_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, rld_q, cmpa_q, cmpb_q, nxt;
  logic         wrap, adv;

  always_comb begin
    wrap = up_i ? (cnt_q == '1) : (cnt_q == '0);
    nxt  = wrap ? rld_q : (up_i ? cnt_q + 1'b1 : cnt_q - 1'b1);
    adv  = tick_i & ~cnt_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '1;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (cnt_we_i)   cnt_q  <= wdata_i;
      else if (tick_i) cnt_q <= nxt;
      if (rld_we_i)   rld_q  <= wdata_i;
      if (cmpa_we_i)  cmpa_q <= wdata_i;
      if (cmpb_we_i)  cmpb_q <= wdata_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign rld_o      = rld_q;
  assign cmpa_o     = cmpa_q;
  assign cmpb_o     = cmpb_q;
  assign cmpa_hit_o = adv & (nxt == cmpa_q);
  assign cmpb_hit_o = adv & (nxt == cmpb_q);
  assign wrap_o     = adv & wrap & wie_i;

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_o));
  // R4
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && !up_i && cnt_o == '0) |=> (cnt_o == $past(rld_o)));
  // R12
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(wdata_i)));
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned W   = 32,
  parameter int unsigned AW  = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  input  logic [NCH-1:0] ext_clk_i,
  output logic           irq_o
);
  localparam int unsigned WW        = AW - 2;
  localparam int unsigned STW       = GRP_BITS * NCH;
  localparam int unsigned CTW       = STW + 1;
  localparam int unsigned UP_BIT    = STW;
  localparam int unsigned CTRL_WORD = NCH * 4;
  localparam int unsigned STAT_WORD = CTRL_WORD + 1;
  localparam int unsigned MASK_WORD = CTRL_WORD + 2;

  logic [WW-1:0]  word;
  logic [CTW-1:0] ctrl_q;
  logic [STW-1:0] stat_q, mask_q, set_vec;
  logic [NCH-1:0] ext_edge, tick;
  logic           stat_we;
  logic [W-1:0]   cnt_a [NCH];
  logic [W-1:0]   rld_a [NCH];
  logic [W-1:0]   cmpa_a[NCH];
  logic [W-1:0]   cmpb_a[NCH];

  assign word    = addr_i[AW-1:2];
  assign stat_we = we_i && (word == WW'(STAT_WORD));

  ext_tick_sync #(.N(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_clk_i),
    .edge_o(ext_edge)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic bank_we;
    assign bank_we = we_i && ((word >> 2) == WW'(k));
    assign tick[k] = ctrl_q[GRP_BITS*k + CTL_EN] &
                     (ctrl_q[GRP_BITS*k + CTL_SRC] ? ext_edge[k] : 1'b1);

    timer_chan #(.W(W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick[k]),
      .up_i      (ctrl_q[UP_BIT]),
      .wie_i     (ctrl_q[GRP_BITS*k + CTL_WIE]),
      .cnt_we_i  (bank_we && word[1:0] == BK_COUNT),
      .rld_we_i  (bank_we && word[1:0] == BK_RELOAD),
      .cmpa_we_i (bank_we && word[1:0] == BK_CMPA),
      .cmpb_we_i (bank_we && word[1:0] == BK_CMPB),
      .wdata_i   (wdata_i),
      .cnt_o     (cnt_a[k]),
      .rld_o     (rld_a[k]),
      .cmpa_o    (cmpa_a[k]),
      .cmpb_o    (cmpb_a[k]),
      .cmpa_hit_o(set_vec[GRP_BITS*k + ST_CMPA]),
      .cmpb_hit_o(set_vec[GRP_BITS*k + ST_CMPB]),
      .wrap_o    (set_vec[GRP_BITS*k + ST_WRAP])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (we_i && word == WW'(CTRL_WORD)) ctrl_q <= wdata_i[CTW-1:0];
      if (we_i && word == WW'(MASK_WORD)) mask_q <= wdata_i[STW-1:0];
      // event set beats write-one-to-clear
      stat_q <= (stat_q & ~(stat_we ? wdata_i[STW-1:0] : '0)) | set_vec;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCH; k++) begin
      if ((word >> 2) == WW'(k)) begin
        case (word[1:0])
          BK_COUNT:  rdata_o = cnt_a[k];
          BK_RELOAD: rdata_o = rld_a[k];
          BK_CMPA:   rdata_o = cmpa_a[k];
          default:   rdata_o = cmpb_a[k];
        endcase
      end
    end
    if (word == WW'(CTRL_WORD)) rdata_o = W'(ctrl_q);
    if (word == WW'(STAT_WORD)) rdata_o = W'(stat_q);
    if (word == WW'(MASK_WORD)) rdata_o = W'(mask_q);
  end

  assign irq_o = |(stat_q & ~mask_q);

  // R9
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R11
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
  // R10
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
endmodule

// File: tb/tb_tri_timer.sv
module tb_tri_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  ext = '0;
  logic        irq;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tri_timer dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .we_i     (we),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .ext_clk_i(ext),
    .irq_o    (irq)
  );

  typedef struct packed {
    logic        rd;
    logic [5:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  // register table: R1 reset values, R6/R10/R12 register access
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h00, 32'h0000_0000, 4'd1},
    '{1'b1, 6'h04, 32'hFFFF_FFFF, 4'd1},
    '{1'b1, 6'h08, 32'h0000_0000, 4'd1},
    '{1'b1, 6'h0C, 32'h0000_0000, 4'd1},
    '{1'b1, 6'h14, 32'hFFFF_FFFF, 4'd1},
    '{1'b1, 6'h24, 32'hFFFF_FFFF, 4'd1},
    '{1'b1, 6'h30, 32'h0000_0000, 4'd1},
    '{1'b1, 6'h34, 32'h0000_0000, 4'd1},
    '{1'b1, 6'h38, 32'h0000_0000, 4'd1},
    '{1'b0, 6'h08, 32'h0000_1234, 4'd6},
    '{1'b1, 6'h08, 32'h0000_1234, 4'd6},
    '{1'b0, 6'h2C, 32'h0000_ABCD, 4'd6},
    '{1'b1, 6'h2C, 32'h0000_ABCD, 4'd6},
    '{1'b0, 6'h38, 32'h0000_01FF, 4'd10},
    '{1'b1, 6'h38, 32'h0000_01FF, 4'd10},
    '{1'b0, 6'h38, 32'h0000_0000, 4'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].a, v);
        chk($sformatf("R%0d table[%0d]", VEC[i].req, i), v, VEC[i].d);
        waitc(1);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end

    // R12 then R2: write lands on a running channel, then count down
    wr(6'h30, 32'h1);
    wr(6'h00, 32'd100);
    rd(6'h00, v); chk("R12 write over tick", v, 32'd100);
    waitc(5);
    rd(6'h00, v); chk("R2 down count", v, 32'd95);

    // R3 up count
    wr(6'h30, 32'h0);
    wr(6'h00, 32'd10);
    wr(6'h30, 32'h201);
    waitc(3);
    rd(6'h00, v); chk("R3 up count", v, 32'd13);

    // R4 underflow with wrap interrupt enabled
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h1FF);
    wr(6'h0C, 32'h3000);
    wr(6'h04, 32'd7);
    wr(6'h00, 32'd2);
    wr(6'h30, 32'h5);
    waitc(3);
    rd(6'h00, v); chk("R4 reload", v, 32'd7);
    rd(6'h34, v); chk("R4 wrap status", v, 32'h4);
    chk("R10 irq unmasked", {31'd0, irq}, 32'd1);
    // R10 masking
    wr(6'h38, 32'h4);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(6'h38, 32'h0);
    chk("R10 irq unmasked again", {31'd0, irq}, 32'd1);
    // R9 zero write keeps, one write clears
    wr(6'h34, 32'h0);
    rd(6'h34, v); chk("R9 zero write ignored", v, 32'h4);
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h4);
    rd(6'h34, v); chk("R9 w1c", v, 32'h0);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);

    // R4 underflow with wrap interrupt disabled
    wr(6'h00, 32'd1);
    wr(6'h30, 32'h1);
    waitc(2);
    rd(6'h00, v); chk("R4 reload no ie", v, 32'd7);
    rd(6'h34, v); chk("R4 no status without ie", v, 32'h0);

    // R5 up overflow
    wr(6'h30, 32'h0);
    wr(6'h04, 32'h20);
    wr(6'h00, 32'hFFFF_FFFE);
    wr(6'h34, 32'h1FF);
    wr(6'h30, 32'h205);
    waitc(2);
    rd(6'h00, v); chk("R5 overflow reload", v, 32'h20);
    rd(6'h34, v); chk("R5 overflow status", v, 32'h4);

    // R6 compare A and B on channel 1
    wr(6'h30, 32'h0);
    wr(6'h18, 32'd40);
    wr(6'h1C, 32'd37);
    wr(6'h10, 32'd45);
    wr(6'h34, 32'h1FF);
    wr(6'h30, 32'h8);
    waitc(5);
    rd(6'h34, v); chk("R6 compare A", v, 32'h8);
    waitc(3);
    rd(6'h34, v); chk("R6 compare B", v, 32'h18);

    // R11 event set collides with w1c on the same edge
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h1FF);
    wr(6'h10, 32'd10);
    wr(6'h18, 32'd5);
    wr(6'h1C, 32'h9999);
    wr(6'h30, 32'h8);
    waitc(4);
    wr(6'h34, 32'h8);
    rd(6'h34, v); chk("R11 set wins over clear", v, 32'h8);
    wr(6'h34, 32'h8);
    rd(6'h34, v); chk("R11 later clear", v, 32'h0);

    // R7 stop one channel, other keeps running
    wr(6'h30, 32'h0);
    wr(6'h00, 32'd500);
    wr(6'h10, 32'd800);
    wr(6'h30, 32'h9);
    waitc(4);
    rd(6'h00, v); chk("R7 ch0 running", v, 32'd496);
    rd(6'h10, v); chk("R7 ch1 running", v, 32'd796);
    wr(6'h30, 32'h8);
    waitc(5);
    rd(6'h00, v); rd(6'h10, v2);
    chk("R7 ch0 frozen", v, 32'd495);
    chk("R7 ch1 continues", v2, 32'd790);

    // R8 external pulses on channel 2
    wr(6'h30, 32'h0);
    wr(6'h20, 32'd1000);
    wr(6'h30, 32'hC0);
    waitc(5);
    rd(6'h20, v); chk("R8 steady low", v, 32'd1000);
    ext[2] = 1'b1;
    waitc(4);
    rd(6'h20, v); chk("R8 one edge", v, 32'd999);
    waitc(4);
    rd(6'h20, v); chk("R8 steady high", v, 32'd999);
    ext[2] = 1'b0;
    waitc(3);
    ext[2] = 1'b1;
    waitc(4);
    rd(6'h20, v); chk("R8 second edge", v, 32'd998);
    wr(6'h30, 32'h80);
    ext[2] = 1'b0;
    waitc(3);
    ext[2] = 1'b1;
    waitc(4);
    rd(6'h20, v); chk("R8 disabled ignores edge", v, 32'd998);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule